// File: doc/BRIEF.md
# Shared Control Part-2 Encoder

This block builds the 80 coded bits that fill the second and third slots of a downlink shared control subframe. On a start strobe it captures the part-1 fields (7-bit code-set field and the modulation flag) and the part-2 fields: transport-block size, HARQ process, redundancy and constellation parameters, new-data flag, and the 16-bit identity of the addressed user. It first turns the redundancy and constellation parameters into a 3-bit version code. It then forms a 13-bit field group and computes a 16-bit CRC over the part-1 byte followed by that group. The CRC is XORed with the user identity, so only the addressed receiver sees a passing check, and it is appended to give 29 bits.

The 29 bits are fed, with an 8-bit zero tail, through a constraint-length-9, rate-1/3 convolutional encoder, giving 111 coded bits. A fixed irregular list of 31 positions is punctured out. The surviving 80 bits leave one at a time on a serial pin with a valid strobe, in ascending coded index order. If the parameter combination has no entry in the version table, the block raises an error flag and sends nothing.

Top module: `sctl_part2_encoder`

## Requirements
- R1: After synchronous reset, `busy_o`, `err_o` and `bit_valid_o` are low.
- R2: The 13-bit field group is, first bit first: transport-block size (MSB first), HARQ process (MSB first), version code (MSB first), new-data flag. The version code is the index 0..7 whose table row matches the inputs. With `mod16_i`=1 (16QAM) the rows of (s,r,b) are (1,0,0),(0,0,0),(1,1,1),(0,1,1),(1,0,1),(1,0,2),(1,0,3),(1,1,0). With `mod16_i`=0 (QPSK) the rows of (s,r) are (1,0),(0,0),(1,1),(0,1),(1,2),(0,2),(1,3),(0,3).
- R3: The CRC uses the generator x^16+x^12+x^5+1 and starts from a zero register. It runs over 21 bits: code-set field (MSB first), then `mod16_i`, then the 13-bit group. Its bits are taken highest degree first, and each is XORed with the identity taken MSB first. The result is appended after the 13-bit group.
- R4: The 29 bits plus 8 zero tail bits are convolutionally encoded with generators 557, 663 and 711 (octal), where the generator MSB taps the current input bit. Each input bit emits three coded bits in generator order, for 111 bits in total.
- R5: The coded bits at 1-based positions 1-8, 12, 14, 15, 24, 42, 48, 54, 57, 60, 66, 69, 96, 99, 101, 102 and 104-111 are dropped.
- R6: Each accepted frame produces exactly 80 strobes of `bit_valid_o`, carrying the surviving bits in ascending coded index order, and no strobe occurs while the block is idle.
- R7: A start whose version inputs match no row sets `err_o` and produces no output bits. The next start with a valid combination clears `err_o`.
- R8: A start while `busy_o` is high is ignored. The running frame is unchanged and no further frame follows it.
- R9: In QPSK mode the `b_i` input has no effect on the output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Capture fields and start a frame (honoured when idle) |
| mod16_i | input | 1 | Modulation flag: 1 = 16QAM, 0 = QPSK; also the last part-1 bit |
| ccs_i | input | 7 | Code-set field of part 1 |
| tbs_i | input | 6 | Transport-block size |
| harq_i | input | 3 | HARQ process number |
| s_i | input | 1 | Systematic-priority parameter |
| r_i | input | 2 | Redundancy parameter |
| b_i | input | 2 | Constellation parameter (16QAM only) |
| ndi_i | input | 1 | New-data flag |
| ue_i | input | 16 | Identity of the addressed user |
| busy_o | output | 1 | Frame in progress |
| err_o | output | 1 | Last start had an unmapped parameter combination |
| bit_valid_o | output | 1 | `bit_o` carries an output bit |
| bit_o | output | 1 | Serial coded bit |

## Verification
The bench sweeps all eight version codes in both modulation modes. A mis-ordered or mis-decoded table would put wrong bits in the field group, and that corrupts the CRC and every coded bit after it. An all-zero frame must code to all zeros. A frame with only the identity set exposes a missing or reversed mask, which shows up as a zero or bit-swapped tail. An off-by-one puncture list or a wrong tail length shows up as a bit count other than 80 or as shifted bits. The bench also checks the unmapped 16QAM combination: a design that streams anyway or keeps a stale error flag fails there. It pulses start mid-frame with new fields, which a design that recaptures inputs while busy would turn into a corrupted or doubled frame. It changes `b_i` under QPSK, which a design that lets that input leak into the mapping would turn into different output.

// File: rtl/sctl_p2_pkg.sv
package sctl_p2_pkg;
  localparam int P1_W    = 8;                 // code-set + modulation flag
  localparam int CCS_W   = P1_W - 1;
  localparam int TBS_W   = 6;
  localparam int HAP_W   = 3;
  localparam int VER_W   = 3;
  localparam int NVER    = 1 << VER_W;
  localparam int P2_W    = TBS_W + HAP_W + VER_W + 1;
  localparam int CRC_W   = 16;
  localparam int MSG_W   = P1_W + P2_W;       // bits covered by the CRC
  localparam int Y_W     = P2_W + CRC_W;      // bits entering the encoder
  localparam int CK      = 9;                 // constraint length
  localparam int NGEN    = 3;                 // inverse code rate
  localparam int ENC_IN  = Y_W + CK - 1;      // with zero tail
  localparam int CODED   = NGEN * ENC_IN;
  localparam int N_PUNCT = 31;
  localparam int OUT_BITS = CODED - N_PUNCT;

  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [NGEN*CK-1:0] GEN_SET = {9'o711, 9'o663, 9'o557};

  typedef enum logic [1:0] {ST_IDLE, ST_CRC, ST_LOAD, ST_CODE} p2_state_t;

  // 1-based coded index -> dropped by rate matching
  function automatic logic is_punct(input int unsigned k);
    if (k >= 1 && k <= 8)     return 1'b1;
    if (k >= 104 && k <= 111) return 1'b1;
    case (k)
      12, 14, 15, 24, 42, 48, 54, 57, 60, 66, 69, 96, 99, 101, 102: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sctl_p2_version_map.sv
module sctl_p2_version_map
  import sctl_p2_pkg::*;
(
  input  logic             mod16_i,
  input  logic             s_i,
  input  logic [1:0]       r_i,
  input  logic [1:0]       b_i,
  output logic [VER_W-1:0] ver_o,
  output logic             bad_o
);
  // {s, r[1:0], b[1:0]} rows for 16QAM
  function automatic logic [4:0] qam_row(input int v);
    case (v)
      0: return 5'b1_00_00;
      1: return 5'b0_00_00;
      2: return 5'b1_01_01;
      3: return 5'b0_01_01;
      4: return 5'b1_00_01;
      5: return 5'b1_00_10;
      6: return 5'b1_00_11;
      default: return 5'b1_01_00;
    endcase
  endfunction

  // {s, r[1:0]} rows for QPSK
  function automatic logic [2:0] qpsk_row(input int v);
    case (v)
      0: return 3'b1_00;
      1: return 3'b0_00;
      2: return 3'b1_01;
      3: return 3'b0_01;
      4: return 3'b1_10;
      5: return 3'b0_10;
      6: return 3'b1_11;
      default: return 3'b0_11;
    endcase
  endfunction

  always_comb begin
    ver_o = '0;
    bad_o = 1'b1;
    for (int v = 0; v < NVER; v++) begin
      if (mod16_i ? (qam_row(v) == {s_i, r_i, b_i}) : (qpsk_row(v) == {s_i, r_i})) begin
        ver_o = VER_W'(v);
        bad_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/sctl_p2_crc.sv
module sctl_p2_crc #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] crc_o
);
  logic fb;
  assign fb = din_i ^ crc_o[W-1];

  always_ff @(posedge clk) begin
    if (rst || clr_i) crc_o <= '0;
    else if (en_i)    crc_o <= {crc_o[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  // R3: a fresh frame never clears and shifts the register at once
  a_r3_clr_en_excl: assert property (@(posedge clk) disable iff (rst)
    !(clr_i && en_i));
endmodule

// File: rtl/sctl_p2_conv_enc.sv
module sctl_p2_conv_enc #(
  parameter int                CK   = 9,
  parameter int                NG   = 3,
  parameter logic [NG*CK-1:0]  GENS = {9'o711, 9'o663, 9'o557},
  localparam int               SW   = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          adv_i,
  input  logic          din_i,
  input  logic [SW-1:0] sel_i,
  output logic          code_o
);
  logic [CK-2:0] st_q;          // st_q[CK-2] = most recent past input
  logic [CK-1:0] win;
  logic [NG-1:0] par;

  assign win = {din_i, st_q};

  for (genvar g = 0; g < NG; g++) begin : g_tap
    assign par[g] = ^(win & GENS[g*CK +: CK]);
  end

  assign code_o = par[sel_i];

  always_ff @(posedge clk) begin
    if (rst || clr_i) st_q <= '0;
    else if (adv_i)   st_q <= {din_i, st_q[CK-2:1]};
  end

  // R4: the zero tail leaves the encoder flushed when a frame ends
  a_r4_tail_flush: assert property (@(posedge clk) disable iff (rst)
    $fell(run_i) |-> (st_q == '0));
endmodule

// File: rtl/sctl_part2_encoder.sv
module sctl_part2_encoder
  import sctl_p2_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             mod16_i,
  input  logic [CCS_W-1:0] ccs_i,
  input  logic [TBS_W-1:0] tbs_i,
  input  logic [HAP_W-1:0] harq_i,
  input  logic             s_i,
  input  logic [1:0]       r_i,
  input  logic [1:0]       b_i,
  input  logic             ndi_i,
  input  logic [CRC_W-1:0] ue_i,
  output logic             busy_o,
  output logic             err_o,
  output logic             bit_valid_o,
  output logic             bit_o
);
  localparam int CC_W = $clog2(MSG_W);
  localparam int KC_W = $clog2(CODED);
  localparam int PH_W = (NGEN > 1) ? $clog2(NGEN) : 1;

  p2_state_t        state;
  logic [VER_W-1:0] ver;
  logic             ver_bad;
  logic [P2_W-1:0]  f2;
  logic [MSG_W-1:0] msg_q;
  logic [P2_W-1:0]  p2_q;
  logic [CRC_W-1:0] ue_q;
  logic [CRC_W-1:0] crc_val;
  logic [CC_W-1:0]  crc_cnt;
  logic [ENC_IN-1:0] ybuf;
  logic [KC_W-1:0]  kcnt;
  logic [PH_W-1:0]  ph;
  logic             code_bit;
  logic             err_q, bit_q, valid_q;
  logic             accept;

  sctl_p2_version_map u_map (
    .mod16_i (mod16_i), .s_i (s_i), .r_i (r_i), .b_i (b_i),
    .ver_o   (ver),     .bad_o (ver_bad)
  );

  assign f2     = {tbs_i, harq_i, ver, ndi_i};
  assign accept = (state == ST_IDLE) && start_i && !ver_bad;

  sctl_p2_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk (clk), .rst (rst),
    .clr_i (accept),
    .en_i  (state == ST_CRC),
    .din_i (msg_q[MSG_W-1]),
    .crc_o (crc_val)
  );

  sctl_p2_conv_enc #(.CK(CK), .NG(NGEN), .GENS(GEN_SET)) u_enc (
    .clk (clk), .rst (rst),
    .clr_i  (state == ST_LOAD),
    .run_i  (state == ST_CODE),
    .adv_i  ((state == ST_CODE) && (ph == PH_W'(NGEN-1))),
    .din_i  (ybuf[ENC_IN-1]),
    .sel_i  (ph),
    .code_o (code_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      err_q   <= 1'b0;
      msg_q   <= '0;
      p2_q    <= '0;
      ue_q    <= '0;
      crc_cnt <= '0;
      ybuf    <= '0;
      kcnt    <= '0;
      ph      <= '0;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            err_q <= ver_bad;
            if (!ver_bad) begin
              msg_q   <= {ccs_i, mod16_i, f2};
              p2_q    <= f2;
              ue_q    <= ue_i;
              crc_cnt <= '0;
              state   <= ST_CRC;
            end
          end
        end
        ST_CRC: begin
          msg_q   <= {msg_q[MSG_W-2:0], 1'b0};
          crc_cnt <= crc_cnt + 1'b1;
          if (crc_cnt == CC_W'(MSG_W-1)) state <= ST_LOAD;
        end
        ST_LOAD: begin
          ybuf  <= {p2_q, crc_val ^ ue_q, {(CK-1){1'b0}}};
          kcnt  <= '0;
          ph    <= '0;
          state <= ST_CODE;
        end
        default: begin
          bit_q   <= code_bit;
          valid_q <= !is_punct(32'(kcnt) + 32'd1);
          if (ph == PH_W'(NGEN-1)) begin
            ph   <= '0;
            ybuf <= {ybuf[ENC_IN-2:0], 1'b0};
          end else begin
            ph <= ph + 1'b1;
          end
          kcnt <= kcnt + 1'b1;
          if (kcnt == KC_W'(CODED-1)) state <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy_o      = (state != ST_IDLE);
  assign err_o       = err_q;
  assign bit_valid_o = valid_q;
  assign bit_o       = bit_q;

  // ---- assertion support: strobes seen since the last accepted start
  logic [KC_W-1:0] vcnt;
  always_ff @(posedge clk) begin
    if (rst || accept)    vcnt <= '0;
    else if (bit_valid_o) vcnt <= vcnt + 1'b1;
  end

  // R6: a finished frame has delivered exactly the surviving bits
  a_r6_eighty_bits: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (vcnt == KC_W'(OUT_BITS)));

  // R6: nothing is strobed once idle has settled
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> !bit_valid_o);

  // R7: an error leaves the serial output silent
  a_r7_err_silent: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !bit_valid_o);

  // R8: captured identity does not move while a frame runs
  a_r8_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(ue_q));
endmodule

// File: tb/test_sctl_part2_encoder.sv
`timescale 1ns/1ps
module test_sctl_part2_encoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, mod16_i = 1'b0, s_i = 1'b0, ndi_i = 1'b0;
  logic [6:0] ccs_i = '0;
  logic [5:0] tbs_i = '0;
  logic [2:0] harq_i = '0;
  logic [1:0] r_i = '0, b_i = '0;
  logic [15:0] ue_i = '0;
  logic busy_o, err_o, bit_valid_o, bit_o;

  int errors = 0;
  int checks = 0;
  int nrx = 0;
  logic [79:0] rx;

  always #2 clk = ~clk;   // 250 MHz

  sctl_part2_encoder i_sctl_part2_encoder (
    .clk (clk), .rst (rst), .start_i (start_i), .mod16_i (mod16_i),
    .ccs_i (ccs_i), .tbs_i (tbs_i), .harq_i (harq_i), .s_i (s_i),
    .r_i (r_i), .b_i (b_i), .ndi_i (ndi_i), .ue_i (ue_i),
    .busy_o (busy_o), .err_o (err_o), .bit_valid_o (bit_valid_o), .bit_o (bit_o)
  );

  always @(negedge clk) begin
    if (!rst && bit_valid_o) begin
      if (nrx < 80) rx[nrx] = bit_o;
      nrx++;
    end
  end

  localparam int QS [8] = '{1,0,1,0,1,1,1,1};
  localparam int QR [8] = '{0,0,1,1,0,0,0,1};
  localparam int QB [8] = '{0,0,1,1,1,2,3,0};
  localparam int PS [8] = '{1,0,1,0,1,0,1,0};
  localparam int PR [8] = '{0,0,1,1,2,2,3,3};
  localparam int PL [31] = '{1,2,3,4,5,6,7,8,12,14,15,24,42,48,54,57,60,66,69,
                             96,99,101,102,104,105,106,107,108,109,110,111};

  function automatic logic [79:0] ref_bits(
      input logic m16, input logic [6:0] ccs, input logic [5:0] tbs,
      input logic [2:0] hap, input logic s, input logic [1:0] r,
      input logic [1:0] b, input logic nd, input logic [15:0] ue);
    logic [2:0]  ver;
    logic [20:0] msg;
    logic [36:0] dv;
    logic [15:0] crc;
    logic [28:0] y;
    logic        u [37];
    logic        z [111];
    logic [8:0]  gb [3];
    logic [79:0] o;
    logic        acc, drop;
    int n;
    gb[0] = 9'o557; gb[1] = 9'o663; gb[2] = 9'o711;
    ver = '0;
    for (int v = 0; v < 8; v++) begin
      if (m16 ? (int'(s) == QS[v] && int'(r) == QR[v] && int'(b) == QB[v])
              : (int'(s) == PS[v] && int'(r) == PR[v]))
        ver = v[2:0];
    end
    msg = {ccs, m16, tbs, hap, ver, nd};
    dv = {msg, 16'h0000};
    for (int i = 36; i >= 16; i--)
      if (dv[i]) dv[i -: 17] = dv[i -: 17] ^ 17'h11021;
    crc = dv[15:0];
    y = {tbs, hap, ver, nd, crc ^ ue};
    for (int t = 0; t < 37; t++) u[t] = (t < 29) ? y[28 - t] : 1'b0;
    for (int t = 0; t < 37; t++)
      for (int j = 0; j < 3; j++) begin
        acc = 1'b0;
        for (int d = 0; d < 9; d++)
          if (t - d >= 0) acc = acc ^ (gb[j][8 - d] & u[t - d]);
        z[3*t + j] = acc;
      end
    o = '0;
    n = 0;
    for (int k = 1; k <= 111; k++) begin
      drop = 1'b0;
      for (int p = 0; p < 31; p++) if (PL[p] == k) drop = 1'b1;
      if (!drop) begin
        if (n < 80) o[n] = z[k - 1];
        n++;
      end
    end
    return o;
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic m16, input logic [6:0] ccs, input logic [5:0] tbs,
                       input logic [2:0] hap, input logic s, input logic [1:0] r,
                       input logic [1:0] b, input logic nd, input logic [15:0] ue);
    mod16_i = m16; ccs_i = ccs; tbs_i = tbs; harq_i = hap;
    s_i = s; r_i = r; b_i = b; ndi_i = nd; ue_i = ue;
  endtask

  task automatic launch();
    nrx = 0; rx = '0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 400 && busy_o; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input string req, input logic m16, input logic [6:0] ccs,
                           input logic [5:0] tbs, input logic [2:0] hap, input logic s,
                           input logic [1:0] r, input logic [1:0] b, input logic nd,
                           input logic [15:0] ue);
    drive(m16, ccs, tbs, hap, s, r, b, nd, ue);
    launch();
    wait_idle();
    chk({"R6 bit count ", req}, 80'(nrx), 80'd80);
    chk({req, " coded bits"}, rx, ref_bits(m16, ccs, tbs, hap, s, r, b, nd, ue));
    chk({"R7 err low ", req}, 80'(err_o), 80'd0);
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", 80'(busy_o), 80'd0);
    chk("R1 err after reset", 80'(err_o), 80'd0);
    chk("R1 valid after reset", 80'(bit_valid_o), 80'd0);
  endtask

  task automatic t_zero_and_mask();
    run_frame("R3 zero frame", 1'b0, 7'h00, 6'h00, 3'h0, 1'b1, 2'd0, 2'd0, 1'b0, 16'h0000);
    chk("R3 zero frame codes to zeros", rx, 80'd0);
    run_frame("R3 identity mask", 1'b0, 7'h00, 6'h00, 3'h0, 1'b1, 2'd0, 2'd0, 1'b0, 16'hA5C3);
    run_frame("R4 R5 mixed fields", 1'b1, 7'h5B, 6'h2D, 3'h6, 1'b0, 2'd1, 2'd1, 1'b1, 16'h3E91);
  endtask

  task automatic t_versions();
    for (int v = 0; v < 8; v++)
      run_frame("R2 16QAM version", 1'b1, 7'(13*v + 5), 6'(7*v + 1), 3'(v), 1'(QS[v]),
                2'(QR[v]), 2'(QB[v]), 1'(v), 16'(16'h1234 * (v + 1)));
    for (int v = 0; v < 8; v++)
      run_frame("R2 QPSK version", 1'b0, 7'(11*v + 3), 6'(5*v + 2), 3'(7 - v), 1'(PS[v]),
                2'(PR[v]), 2'd0, 1'(~v), 16'(16'hBEEF ^ (v << 4)));
  endtask

  task automatic t_invalid();
    drive(1'b1, 7'h11, 6'h22, 3'h3, 1'b0, 2'd0, 2'd1, 1'b1, 16'h7777);
    launch();
    repeat (200) @(negedge clk);
    chk("R7 err set for unmapped combination", 80'(err_o), 80'd1);
    chk("R7 no bits for unmapped combination", 80'(nrx), 80'd0);
    chk("R7 stays idle", 80'(busy_o), 80'd0);
    run_frame("R7 recovery", 1'b1, 7'h11, 6'h22, 3'h3, 1'b1, 2'd0, 2'd2, 1'b1, 16'h7777);
  endtask

  task automatic t_busy_ignore();
    logic [79:0] expv;
    expv = ref_bits(1'b1, 7'h3C, 6'h15, 3'h2, 1'b1, 2'd1, 2'd1, 1'b0, 16'hC0DE);
    drive(1'b1, 7'h3C, 6'h15, 3'h2, 1'b1, 2'd1, 2'd1, 1'b0, 16'hC0DE);
    launch();
    repeat (40) @(negedge clk);
    drive(1'b0, 7'h7F, 6'h3F, 3'h7, 1'b0, 2'd3, 2'd0, 1'b1, 16'hFFFF);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    chk("R8 frame unchanged by start while busy", rx, expv);
    repeat (200) @(negedge clk);
    chk("R8 no extra frame", 80'(nrx), 80'd80);
  endtask

  task automatic t_qpsk_b();
    logic [79:0] first;
    run_frame("R9 QPSK b=0", 1'b0, 7'h2A, 6'h0F, 3'h5, 1'b0, 2'd2, 2'd0, 1'b1, 16'h5A5A);
    first = rx;
    run_frame("R9 QPSK b=3", 1'b0, 7'h2A, 6'h0F, 3'h5, 1'b0, 2'd2, 2'd3, 1'b1, 16'h5A5A);
    chk("R9 b ignored in QPSK", rx, first);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero_and_mask();
    t_versions();
    t_invalid();
    t_busy_ignore();
    t_qpsk_b();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule